// File: doc/BRIEF.md
# Dual Event-Selectable Performance Counters

This block holds two performance counters. Each one counts an event that software picks from a menu of sixteen codes. The two 4-bit codes sit together in one control word, and that word also carries one write-one clear bit per counter. Code 0 counts every clock on both counters. Codes 1, 2 and 4 take the same three shared event inputs on both counters. Codes 5 to 15 take a private set of eleven inputs that differs between the two counters. Code 3 counts nothing. Each menu code is either a level ("busy") event, counted on every cycle it is high, or a request event, counted once per rising edge.

Software works through a simple register port. Reads return data combinationally in the cycle the read is presented. A read of counter 0 takes a snapshot of counter 1 into a shadow register on the same clock edge, so a later read of the shadow returns a value taken at the same instant as the counter 0 value. Counter 1 has no register index of its own and is seen only through the shadow. To change an event, software writes the new code together with that counter's clear bit, so the count starts again from zero on the new event.

Top module: `perf_pair_ctr`

## Requirements
- R1: While reset is asserted, counter 0, the shadow and the control word all read 0, and both selectors are 0.
- R2: The control word is at index 0x20. The counter 0 selector is in bits 3:0 and the counter 1 selector is in bits 11:8. Every other bit reads back as 0.
- R3: Writing 1 to control bit 7 zeroes counter 0, and writing 1 to bit 15 zeroes counter 1. Both bits read back as 0. A write with the bit at 0 leaves that counter's value alone.
- R4: Selector 0 makes a counter advance by one on every clock.
- R5: On both counters, codes 1, 2 and 4 count rising edges of evt_shared[0], evt_shared[1] and evt_shared[2] in that order. A pulse on a shared input that is not selected is not counted.
- R6: Codes 5 to 15 select evt_c0[code-5] for counter 0 and evt_c1[code-5] for counter 1. Code 3 never counts.
- R7: With the default menus, counter 0 codes 5, 6, 7, 9 and 10 are busy events, counted once per cycle while high. Every other nonzero code on either counter counts once per rising edge. A counter changes by at most one per cycle.
- R8: A counter wraps from its all-ones value to 0 without saturating. The width is the CNT_W parameter (default 32).
- R9: A clear and an increment in the same cycle leave the counter at 0.
- R10: A read at index 0x08 returns counter 0 and, on the same edge, copies counter 1 into the shadow. A read at index 0x10 returns the shadow. The shadow changes at no other time, and a clear of counter 1 does not touch it.
- R11: Reads of any other index return 0. Writes to any index other than 0x20 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of 0x08 triggers the shadow snapshot) |
| reg_idx | input | 8 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_idx and current state |
| evt_shared | input | 3 | Events common to both menus (codes 1, 2, 4) |
| evt_c0 | input | 11 | Private events of counter 0 (codes 5 to 15) |
| evt_c1 | input | 11 | Private events of counter 1 (codes 5 to 15) |

## Verification
A clear and an increment can land on the same clock edge. The bench sets up this collision by writing a clear bit while that counter is on selector 0, where it advances every cycle. The counter must read exactly 0 on the next cycle, not 1. The second collision is between the shadow snapshot and ongoing counting. The bench clears both clock-counting counters in one write, reads counter 0 some cycles later, and then expects the shadow read to return the very same value even though counter 1 has kept running in between.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int SEL_W    = 4;
  localparam int N_SEL    = 1 << SEL_W;
  localparam int N_SHARED = 3;
  localparam int N_PRIV   = N_SEL - 5;
  localparam int N_CNT    = 2;
  localparam int IDX_W    = 8;
  localparam int DATA_W   = 32;

  localparam logic [IDX_W-1:0] CNT0_IDX   = 8'h08;
  localparam logic [IDX_W-1:0] SHADOW_IDX = 8'h10;
  localparam logic [IDX_W-1:0] CTRL_IDX   = 8'h20;

  localparam int SEL0_LSB = 0;
  localparam int CLR0_BIT = 7;
  localparam int SEL1_LSB = 8;
  localparam int CLR1_BIT = 15;

  typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/perf_rst_sync.sv
module perf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_s_n <= stage_q;
    end
  end
endmodule

// File: rtl/perf_ctrl_reg.sv
module perf_ctrl_reg
  import perf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  sel_t w_sel0,
  input  sel_t w_sel1,
  input  logic w_clr0,
  input  logic w_clr1,
  output sel_t sel0,
  output sel_t sel1,
  output logic clr0,
  output logic clr1
);
  sel_t sel0_d, sel1_d;

  // clear requests are pulses taken straight from the write; never stored
  always_comb begin
    sel0_d = w_sel0;
    sel1_d = w_sel1;
    clr0   = wr_en & w_clr0;
    clr1   = wr_en & w_clr1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel0 <= '0;
      sel1 <= '0;
    end else if (wr_en) begin
      sel0 <= sel0_d;
      sel1 <= sel1_d;
    end
  end
endmodule

// File: rtl/perf_evt_src.sv
module perf_evt_src
  import perf_pkg::*;
#(
  parameter logic [N_SEL-1:0] EDGE_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SEL-1:0] lvl,
  input  sel_t             sel,
  output logic             inc
);
  logic [N_SEL-1:0] hit;

  for (genvar i = 0; i < N_SEL; i++) begin : g_bit
    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl[i];
      end
      assign hit[i] = lvl[i] & ~prev_q;
    end else begin : g_level
      assign hit[i] = lvl[i];
    end
  end

  assign inc = hit[sel];
endmodule

// File: rtl/perf_counter.sv
module perf_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  // clear wins over increment; natural wrap on overflow
  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/perf_pair_ctr.sv
module perf_pair_ctr
  import perf_pkg::*;
#(
  parameter int               CNT_W      = 32,
  parameter logic [N_SEL-1:0] EDGE_MASK0 = 16'hF916,
  parameter logic [N_SEL-1:0] EDGE_MASK1 = 16'hFFF6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [IDX_W-1:0]    reg_idx,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [N_SHARED-1:0] evt_shared,
  input  logic [N_PRIV-1:0]   evt_c0,
  input  logic [N_PRIV-1:0]   evt_c1
);
  logic rst_s_n;
  logic wr_ctrl, rd_cnt0;
  logic [N_CNT-1:0][SEL_W-1:0]  sel;
  logic [N_CNT-1:0]             clr;
  logic [N_CNT-1:0]             inc;
  logic [N_CNT-1:0][CNT_W-1:0]  cnt;
  logic [N_CNT-1:0][N_PRIV-1:0] priv;
  logic [CNT_W-1:0]             shadow_q, shadow_d;
  logic                         unused_wbits;

  perf_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  assign wr_ctrl = reg_wr && (reg_idx == CTRL_IDX);
  assign rd_cnt0 = reg_rd && (reg_idx == CNT0_IDX);
  assign unused_wbits = ^{reg_wdata[31:16], reg_wdata[14:12], reg_wdata[6:4]};

  perf_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .wr_en  (wr_ctrl),
    .w_sel0 (reg_wdata[SEL0_LSB +: SEL_W]),
    .w_sel1 (reg_wdata[SEL1_LSB +: SEL_W]),
    .w_clr0 (reg_wdata[CLR0_BIT]),
    .w_clr1 (reg_wdata[CLR1_BIT]),
    .sel0   (sel[0]),
    .sel1   (sel[1]),
    .clr0   (clr[0]),
    .clr1   (clr[1])
  );

  assign priv[0] = evt_c0;
  assign priv[1] = evt_c1;

  for (genvar g = 0; g < N_CNT; g++) begin : g_ctr
    localparam logic [N_SEL-1:0] MASK = (g == 0) ? EDGE_MASK0 : EDGE_MASK1;
    logic [N_SEL-1:0] menu;
    // code 0: clock, 1/2/4: shared, 3: none, 5..15: private
    assign menu = {priv[g], evt_shared[2], 1'b0, evt_shared[1], evt_shared[0], 1'b1};

    perf_evt_src #(.EDGE_MASK(MASK)) u_src (
      .clk   (clk),
      .rst_n (rst_s_n),
      .lvl   (menu),
      .sel   (sel[g]),
      .inc   (inc[g])
    );

    perf_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_s_n),
      .clr   (clr[g]),
      .inc   (inc[g]),
      .cnt   (cnt[g])
    );
  end

  always_comb shadow_d = rd_cnt0 ? cnt[1] : shadow_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     shadow_q <= '0;
    else if (rd_cnt0) shadow_q <= shadow_d;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_idx)
      CNT0_IDX:   reg_rdata = DATA_W'(cnt[0]);
      SHADOW_IDX: reg_rdata = DATA_W'(shadow_q);
      CTRL_IDX: begin
        reg_rdata[SEL0_LSB +: SEL_W] = sel[0];
        reg_rdata[SEL1_LSB +: SEL_W] = sel[1];
      end
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/perf_pair_chk.sv
module perf_pair_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [7:0]       reg_idx,
  input logic             wclr0,
  input logic             wclr1,
  input logic [19:0]      rd_hi,
  input logic [3:0]       rd_mid,
  input logic [3:0]       sel0,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1,
  input logic [CNT_W-1:0] shadow
);
  logic wr_ctrl, rd_c0;
  assign wr_ctrl = reg_wr && (reg_idx == perf_pkg::CTRL_IDX);
  assign rd_c0   = reg_rd && (reg_idx == perf_pkg::CNT0_IDX);

  // R3
  clr0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wclr0) |=> (cnt0 == '0));

  // R3
  clr1_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wclr1) |=> (cnt1 == '0));

  // R4
  clk_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel0 == 4'd0) && !(wr_ctrl && wclr0)) |=> (cnt0 == CNT_W'($past(cnt0) + 1'b1)));

  // R7
  step_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ctrl && wclr0) |=> ((cnt0 == $past(cnt0)) || (cnt0 == CNT_W'($past(cnt0) + 1'b1))));

  // R10
  shadow_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_c0 |=> (shadow == $past(cnt1)));

  // R10
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_c0 |=> $stable(shadow));

  // R2
  ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == perf_pkg::CTRL_IDX) |-> ((rd_hi == '0) && (rd_mid == '0)));
endmodule

bind perf_pair_ctr perf_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_s_n),
  .reg_wr  (reg_wr),
  .reg_rd  (reg_rd),
  .reg_idx (reg_idx),
  .wclr0   (reg_wdata[perf_pkg::CLR0_BIT]),
  .wclr1   (reg_wdata[perf_pkg::CLR1_BIT]),
  .rd_hi   (reg_rdata[31:12]),
  .rd_mid  (reg_rdata[7:4]),
  .sel0    (sel[0]),
  .cnt0    (cnt[0]),
  .cnt1    (cnt[1]),
  .shadow  (shadow_q)
);

// File: tb/sim_perf_pair_ctr.sv
module sim_perf_pair_ctr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_idx = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] rdata0, rdata1;
  logic [2:0]  evt_shared = 3'b000;
  logic [10:0] evt_c0 = 11'h0;
  logic [10:0] evt_c1 = 11'h0;
  int n_chk = 0;
  int n_fail = 0;

  localparam logic [7:0] I_CNT0 = 8'h08;
  localparam logic [7:0] I_SHD  = 8'h10;
  localparam logic [7:0] I_CTRL = 8'h20;

  always #4 clk = ~clk;

  perf_pair_ctr u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(rdata0), .evt_shared(evt_shared),
    .evt_c0(evt_c0), .evt_c1(evt_c1)
  );

  perf_pair_ctr #(.CNT_W(8)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(rdata1), .evt_shared(evt_shared),
    .evt_c0(evt_c0), .evt_c1(evt_c1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [7:0] idx, input logic [31:0] d);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 32'h0;
  endtask

  // called at a negedge; samples current state, returns one edge later
  task automatic rd(input logic [7:0] idx, output logic [31:0] v0, output logic [31:0] v1);
    reg_rd = 1'b1; reg_idx = idx;
    #1;
    v0 = rdata0; v1 = rdata1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] a, b;
    reg_idx = I_CNT0; #1; chk("R1 cnt0 in reset", rdata0, 32'h0);
    reg_idx = I_SHD;  #1; chk("R1 shadow in reset", rdata0, 32'h0);
    reg_idx = I_CTRL; #1; chk("R1 ctrl in reset", rdata0, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(I_CTRL, a, b); chk("R1 selectors after reset", a, 32'h0);
  endtask

  task automatic t_clk_count;
    logic [31:0] a, b;
    wr(I_CTRL, 32'h8080);
    repeat (10) @(negedge clk);
    rd(I_CNT0, a, b); chk("R4 clock count", a, 32'd10);
    repeat (5) @(negedge clk);
    rd(I_SHD, a, b); chk("R10 coherent shadow", a, 32'd10);
  endtask

  task automatic t_clear_priority;
    logic [31:0] a, b;
    wr(I_CTRL, 32'h0080);
    rd(I_CNT0, a, b); chk("R9 clear beats increment", a, 32'h0);
    rd(I_SHD, a, b); chk("R3 counter 1 kept when only bit 7 set", a != 0, 1'b1);
    wr(I_CTRL, 32'h8585);
    rd(I_CTRL, a, b); chk("R3 clear bits read 0", a, 32'h0505);
  endtask

  task automatic t_shared;
    logic [31:0] a, b;
    wr(I_CTRL, 32'h8181);
    for (int i = 0; i < 3; i++) begin
      evt_shared = 3'b001; @(negedge clk);
      evt_shared = 3'b000; @(negedge clk);
    end
    evt_shared = 3'b010; @(negedge clk);
    evt_shared = 3'b000; @(negedge clk);
    rd(I_CNT0, a, b); chk("R5 code 1 counter 0", a, 32'd3);
    rd(I_SHD, a, b);  chk("R5 code 1 counter 1", a, 32'd3);
    wr(I_CTRL, 32'h8282);
    evt_shared = 3'b010;
    repeat (5) @(negedge clk);
    evt_shared = 3'b000; @(negedge clk);
    rd(I_CNT0, a, b); chk("R5 stretched request counted once c0", a, 32'd1);
    rd(I_SHD, a, b);  chk("R5 stretched request counted once c1", a, 32'd1);
  endtask

  task automatic t_busy_req;
    logic [31:0] a, b;
    wr(I_CTRL, 32'h8585);
    evt_c0 = 11'h001; evt_c1 = 11'h001;
    repeat (4) @(negedge clk);
    evt_c0 = 11'h000; evt_c1 = 11'h000;
    @(negedge clk);
    rd(I_CNT0, a, b); chk("R7 busy counts cycles", a, 32'd4);
    rd(I_SHD, a, b);  chk("R7 request counts edges", a, 32'd1);
  endtask

  task automatic t_private;
    logic [31:0] a, b;
    wr(I_CTRL, 32'h8F83);
    evt_shared = 3'b111; evt_c0 = 11'h7FF; evt_c1 = 11'h400;
    @(negedge clk);
    evt_shared = 3'b000; evt_c0 = 11'h000; evt_c1 = 11'h000;
    @(negedge clk);
    rd(I_CNT0, a, b); chk("R6 code 3 never counts", a, 32'd0);
    rd(I_SHD, a, b);  chk("R6 code 15 uses evt_c1[10]", a, 32'd1);
  endtask

  task automatic t_decode;
    logic [31:0] a, b;
    wr(I_CTRL, 32'h0585);
    evt_c0 = 11'h001;
    repeat (2) @(negedge clk);
    evt_c0 = 11'h000;
    @(negedge clk);
    wr(I_CNT0, 32'h0000FFFF);
    wr(I_SHD,  32'h00008080);
    wr(8'h00,  32'h00008080);
    rd(I_CNT0, a, b); chk("R11 stray writes ignored", a, 32'd2);
    rd(I_CTRL, a, b); chk("R2 selectors unchanged by stray writes", a, 32'h0505);
    rd(8'h04, a, b);  chk("R11 unmapped read", a, 32'h0);
    rd(8'h0C, a, b);  chk("R11 no direct counter 1 index", a, 32'h0);
    wr(I_CTRL, 32'hFFFFFFFF);
    rd(I_CTRL, a, b); chk("R2 field layout all-ones write", a, 32'h0F0F);
  endtask

  task automatic t_wrap;
    logic [31:0] a, b;
    wr(I_CTRL, 32'h8080);
    repeat (255) @(negedge clk);
    rd(I_CNT0, a, b); chk("R8 narrow counter at all-ones", b, 32'd255);
    rd(I_CNT0, a, b); chk("R8 narrow counter wrapped to 0", b, 32'd0);
    chk("R8 wide counter did not wrap", a, 32'd256);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_clk_count;
    t_clear_priority;
    t_shared;
    t_busy_req;
    t_private;
    t_decode;
    t_wrap;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule